// File: doc/BRIEF.md
# MDIO Link Status Poller

This block is a management-bus master that keeps watch on one Ethernet PHY. It generates the management clock MDC from the system clock. Over and over, it sends a read of the PHY's basic status register (address 1) on the shared MDIO line, collects the 16-bit reply and turns it into a set of registered status flags. Each poll gives a one-cycle strobe together with the raw word. The surrounding logic can then react to link changes without running any software.

The frame begins with a preamble of 32 ones. After that come the start pattern 01, the read opcode 10, the 5-bit PHY address and the 5-bit register address 00001, all sent most significant bit first. Next comes a two-bit turnaround and then 16 data bits that the PHY drives. A PHY may signal in bit 6 of its status word that it accepts frames without a preamble. Once any reply has shown that bit set, every later frame starts directly with the start pattern. A fixed idle time separates one read from the next, and the poll-enable input gates the start of new frames.

Top module: `mdio_status_poller`

## Requirements
- R1: MDC is low in reset and then toggles every MDC_HALF system clocks, so its period is 2*MDC_HALF clocks. It runs whether or not a frame is in progress.
- R2: The master changes mdio_o and mdio_oe only in the system clock where MDC falls. It samples mdio_i in the system clock where MDC rises.
- R3: Each frame sends, MSB first, the start bits 0 then 1, the opcode bits 1 then 0, the 5-bit phy_addr, and the register address 00001. Without suppression, 32 driven ones come before these bits.
- R4: mdio_oe is high from the first driven bit through the first turnaround bit, in which mdio_o is 1. It is low from the second turnaround bit through the last data bit, and it stays low between frames.
- R5: The 16 data bits are sampled MSB first on the MDC rising edges that follow the second turnaround bit, and they appear on status_word.
- R6: status_valid is high for exactly one system clock. That clock comes one clock after the MDC rising edge that samples the last data bit. status_word changes only when status_valid is high.
- R7: The flags decode the word as follows: link_up is bit 2, an_done is bit 5, remote_fault is bit 4, jabber is bit 1, an_capable is bit 3 and ext_regs is bit 0. They update together with status_word.
- R8: After a completed read whose bit 6 is 1, every later frame leaves out the 32-bit preamble. This state is held until reset, and a later reply with bit 6 clear does not cancel it.
- R9: A new frame starts only on an MDC falling edge. That edge is at least IDLE_CYCLES system clocks after the clock in which status_valid was high, and it is the first such edge once that time has passed.
- R10: While poll_en is low, no new frame starts. A frame that is already in progress still completes and reports its word.
- R11: In reset, mdc=0, mdio_o=1, mdio_oe=0, status_valid=0, status_word=0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_en | input | 1 | Allows new status reads to start |
| phy_addr | input | 5 | Address of the PHY to poll, latched at frame start |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Value driven on MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable (high = master drives) |
| mdio_i | input | 1 | Value sampled from the shared MDIO line |
| link_up | output | 1 | Link established (status bit 2) |
| an_done | output | 1 | Autonegotiation complete (status bit 5) |
| remote_fault | output | 1 | Remote fault (status bit 4) |
| jabber | output | 1 | Jabber detected (status bit 1) |
| an_capable | output | 1 | Autonegotiation capable (status bit 3) |
| ext_regs | output | 1 | Extended registers exist (status bit 0) |
| status_valid | output | 1 | One-clock strobe for a new status word |
| status_word | output | 16 | Raw status word from the last read |

## Verification
All data on the line moves at MDC rate. The bench's PHY model therefore decodes the master's bits on MDC rising edges and drives its own reply on MDC falling edges. These are the same edges on which the RTL acts, so the bit a check expects is on the line by the time it is sampled. status_valid is due exactly one system clock after the MDC rise that samples the last data bit. The bench records the cycle number of that rise and compares it with the cycle in which it sees the strobe, sampling 1 ns after the clock edge. The start of the next frame is due on the first MDC fall after IDLE_CYCLES clocks, which is at most one MDC period later. For that reason the gap check takes a window of IDLE_CYCLES to IDLE_CYCLES + 2*MDC_HALF clocks. Preamble length, header bits and release of the output enable are measured per frame at MDC edges, and each is checked once the frame's strobe has been seen.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;
  localparam int PRE_BITS    = 32;
  localparam int HDR_BITS    = 14;
  localparam int DATA_BITS   = 16;
  localparam int POS_W       = 6;
  localparam int HDR_LAST    = PRE_BITS + HDR_BITS - 1;   // 45
  localparam int TA1_POS     = HDR_LAST + 1;              // 46
  localparam int DATA_FIRST  = TA1_POS + 2;               // 48
  localparam int FRAME_LAST  = DATA_FIRST + DATA_BITS - 1; // 63
  localparam logic [4:0] STATUS_REG = 5'd1;

  // bit positions inside the status word
  localparam int B_EXT   = 0;
  localparam int B_JAB   = 1;
  localparam int B_LINK  = 2;
  localparam int B_ANCAP = 3;
  localparam int B_RFLT  = 4;
  localparam int B_ANOK  = 5;
  localparam int B_NOPRE = 6;

  typedef struct packed {
    logic link;
    logic an_ok;
    logic rflt;
    logic jab;
    logic an_cap;
    logic ext;
  } phy_flags_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int MDC_HALF = 20
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = $clog2(MDC_HALF) + 1;
  localparam logic [CW-1:0] WRAP = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = (cnt == WRAP);
  assign rise_ev = wrap && !mdc;
  assign fall_ev = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_read_engine.sv
module mdio_read_engine
  import mdio_poll_pkg::*;
#(
  parameter int IDLE_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        poll_en,
  input  logic [4:0]  phy_addr,
  input  logic        mdio_i,
  input  logic        rise_ev,
  input  logic        fall_ev,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] word
);
  localparam int GW = $clog2(IDLE_CYCLES + 1);

  logic              busy;
  logic              skip_pre;
  logic [POS_W-1:0]  pos;
  logic [HDR_BITS-1:0] hdr;
  logic [15:0]       shreg;
  logic [GW-1:0]     gap;

  logic [POS_W-1:0]    start_pos, nxt_pos;
  logic [HDR_BITS-1:0] new_hdr, nxt_hdr;
  logic [15:0]         cap_word;
  logic                can_start;

  function automatic logic bit_at(input logic [POS_W-1:0] p,
                                  input logic [HDR_BITS-1:0] h);
    logic [POS_W-1:0] idx;
    idx = POS_W'(HDR_LAST) - p;
    if (p < POS_W'(PRE_BITS))      return 1'b1;
    else if (p <= POS_W'(HDR_LAST)) return h[idx[3:0]];
    else                            return 1'b1;
  endfunction

  always_comb begin
    start_pos = skip_pre ? POS_W'(PRE_BITS) : '0;
    new_hdr   = {2'b01, 2'b10, phy_addr, STATUS_REG};
    nxt_pos   = busy ? pos + 1'b1 : start_pos;
    nxt_hdr   = busy ? hdr : new_hdr;
    cap_word  = {shreg[14:0], mdio_i};
    can_start = !busy && poll_en && (gap == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      skip_pre <= 1'b0;
      pos      <= '0;
      hdr      <= '0;
      shreg    <= '0;
      gap      <= '0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      done     <= 1'b0;
      word     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && gap != '0) gap <= gap - 1'b1;
      if (fall_ev && (busy || can_start)) begin
        busy    <= 1'b1;
        pos     <= nxt_pos;
        hdr     <= nxt_hdr;
        mdio_o  <= bit_at(nxt_pos, nxt_hdr);
        mdio_oe <= (nxt_pos <= POS_W'(TA1_POS));
      end
      if (rise_ev && busy && pos >= POS_W'(DATA_FIRST)) begin
        shreg <= cap_word;
        if (pos == POS_W'(FRAME_LAST)) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          word     <= cap_word;
          gap      <= GW'(IDLE_CYCLES);
          skip_pre <= skip_pre | cap_word[B_NOPRE];
        end
      end
    end
  end
endmodule

// File: rtl/mdio_status_decode.sv
module mdio_status_decode
  import mdio_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        done,
  input  logic [15:0] word,
  output logic        valid,
  output logic [15:0] status_word,
  output phy_flags_t  flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid       <= 1'b0;
      status_word <= '0;
      flags       <= '0;
    end else begin
      valid <= done;
      if (done) begin
        status_word  <= word;
        flags.link   <= word[B_LINK];
        flags.an_ok  <= word[B_ANOK];
        flags.rflt   <= word[B_RFLT];
        flags.jab    <= word[B_JAB];
        flags.an_cap <= word[B_ANCAP];
        flags.ext    <= word[B_EXT];
      end
    end
  end
endmodule

// File: rtl/mdio_status_poller.sv
module mdio_status_poller
  import mdio_poll_pkg::*;
#(
  parameter int MDC_HALF    = 20,
  parameter int IDLE_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        poll_en,
  input  logic [4:0]  phy_addr,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        link_up,
  output logic        an_done,
  output logic        remote_fault,
  output logic        jabber,
  output logic        an_capable,
  output logic        ext_regs,
  output logic        status_valid,
  output logic [15:0] status_word
);
  logic        rise_ev, fall_ev, done;
  logic [15:0] word;
  phy_flags_t  flags;

  mdio_clk_gen #(.MDC_HALF(MDC_HALF)) u_clk (
    .clk(clk), .rst(rst), .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_read_engine #(.IDLE_CYCLES(IDLE_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .poll_en(poll_en), .phy_addr(phy_addr),
    .mdio_i(mdio_i), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .word(word)
  );

  mdio_status_decode u_dec (
    .clk(clk), .rst(rst), .done(done), .word(word),
    .valid(status_valid), .status_word(status_word), .flags(flags)
  );

  assign link_up      = flags.link;
  assign an_done      = flags.an_ok;
  assign remote_fault = flags.rflt;
  assign jabber       = flags.jab;
  assign an_capable   = flags.an_cap;
  assign ext_regs     = flags.ext;
endmodule

// File: rtl/mdio_status_poller_chk.sv
module mdio_status_poller_chk (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        status_valid,
  input logic [15:0] status_word
);
  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    status_valid |=> !status_valid);

  // R6
  word_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_word) |-> status_valid);

  // R2
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc));

  // R2
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_oe) |-> $fell(mdc));

  // R4
  released_at_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_valid) |-> !mdio_oe);
endmodule

bind mdio_status_poller mdio_status_poller_chk u_chk (.*);

// File: tb/mdio_status_poller_bench.sv
module mdio_status_poller_bench;
  localparam int HALF = 4;
  localparam int IDLE = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic poll_en = 1'b0;
  logic [4:0] phy_addr = 5'd0;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  logic link_up, an_done, remote_fault, jabber, an_capable, ext_regs;
  logic status_valid;
  logic [15:0] status_word;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // PHY model state
  int st = 0, ones_run = 0, last_pre = -1, hcnt = 0, tcnt = 0, oe_viol = 0;
  int last_rise_cyc = 0, start_cyc = 0, starts = 0, mdc_prev = 0, mdc_per = 0;
  logic [13:0] hdr_sh = '0, last_hdr = '0;
  logic [15:0] phy_word = '0, cur_word = '0;
  logic phy_drive = 1'b0, phy_bit = 1'b1;

  assign mdio_i = phy_drive ? phy_bit : 1'b1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_status_poller #(.MDC_HALF(HALF), .IDLE_CYCLES(IDLE)) u_mdio_status_poller (
    .clk(clk), .rst(rst), .poll_en(poll_en), .phy_addr(phy_addr),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .link_up(link_up), .an_done(an_done), .remote_fault(remote_fault),
    .jabber(jabber), .an_capable(an_capable), .ext_regs(ext_regs),
    .status_valid(status_valid), .status_word(status_word)
  );

  always @(posedge mdio_oe) begin
    start_cyc = cyc;
    starts++;
  end

  always @(posedge mdc or negedge mdc) begin
    if (mdc === 1'b1) begin
      mdc_per  = cyc - mdc_prev;
      mdc_prev = cyc;
      case (st)
        0: if (mdio_oe) begin
             if (mdio_o) ones_run++;
             else begin st = 1; hdr_sh = '0; hcnt = 1; end
           end
        1: begin
             hdr_sh = {hdr_sh[12:0], mdio_o};
             hcnt++;
             if (hcnt == 14) begin
               last_hdr = hdr_sh; last_pre = ones_run; ones_run = 0;
               st = 2; tcnt = 0; cur_word = phy_word;
             end
           end
        default: begin
          if (tcnt == 1 && !(mdio_oe && mdio_o)) oe_viol++;
          if (tcnt >= 2 && mdio_oe) oe_viol++;
          if (tcnt == 18) last_rise_cyc = cyc;
        end
      endcase
    end else if (mdc === 1'b0 && st == 2) begin
      tcnt++;
      if (tcnt == 2) begin phy_drive = 1'b1; phy_bit = 1'b0; end
      else if (tcnt >= 3 && tcnt <= 18) phy_bit = cur_word[18 - tcnt];
      else if (tcnt == 19) begin phy_drive = 1'b0; st = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_flags(input logic [15:0] w);
    return {w[2], w[5], w[4], w[1], w[3], w[0]};
  endfunction

  task automatic wait_valid(output bit found, output int vcyc);
    found = 0; vcyc = 0;
    for (int k = 0; k < 3000 && !found; k++) begin
      @(posedge clk); #1;
      if (status_valid) begin found = 1; vcyc = cyc; end
    end
  endtask

  task automatic one_read(input logic [15:0] w, input int exp_pre, input int prev_vcyc);
    bit found; int vcyc; int s0;
    phy_word = w;
    s0 = starts;
    wait_valid(found, vcyc);
    check(found, "R5 valid seen", found, 1);
    if (!found) return;
    check(status_word == w, "R5/R2 word", status_word, w);
    check({link_up, an_done, remote_fault, jabber, an_capable, ext_regs} == exp_flags(w),
          "R7 flags", {link_up, an_done, remote_fault, jabber, an_capable, ext_regs}, exp_flags(w));
    check(last_pre == exp_pre, "R3/R8 preamble", last_pre, exp_pre);
    check(last_hdr == {4'b0110, phy_addr, 5'b00001}, "R3 header", last_hdr,
          {4'b0110, phy_addr, 5'b00001});
    check(oe_viol == 0, "R4 turnaround release", oe_viol, 0);
    check(vcyc - last_rise_cyc == 1, "R6 valid timing", vcyc - last_rise_cyc, 1);
    if (prev_vcyc > 0 && starts == s0 + 1)
      check(start_cyc - prev_vcyc >= IDLE && start_cyc - prev_vcyc <= IDLE + 2*HALF,
            "R9 idle gap", start_cyc - prev_vcyc, IDLE);
    @(posedge clk); #1;
    check(!status_valid, "R6 strobe width", status_valid, 0);
  endtask

  initial begin
    int vprev; bit found; int vcyc; bit seen6; logic [15:0] w; int s0;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(posedge clk);
    #1;
    // R11
    check(mdc == 0 && mdio_oe == 0 && mdio_o == 1 && status_valid == 0,
          "R11 reset pins", {mdc, mdio_oe, mdio_o, status_valid}, 4'b0010);
    check(status_word == 0 && {link_up, an_done, remote_fault, jabber, an_capable, ext_regs} == 0,
          "R11 reset word", status_word, 0);
    rst = 1'b0;
    repeat (200) @(posedge clk);
    #1;
    check(starts == 0, "R10 no frame while disabled", starts, 0);
    check(mdc_per == 2*HALF, "R1 mdc period", mdc_per, 2*HALF);

    poll_en = 1'b1;
    vprev = 0; seen6 = 0;
    for (int i = 0; i < 14; i++) begin
      phy_addr = 5'($urandom);
      w = 16'($urandom);
      if (i < 2) w[6] = 1'b0;
      else if (i == 2) w[6] = 1'b1;
      else if (i == 3) w[6] = 1'b0;   // R8 sticky: clear bit must not restore preamble
      if (i == 4) w = 16'h0000;
      if (i == 5) w = 16'hFFFF;
      one_read(w, seen6 ? 0 : 32, vprev);
      vprev = cyc - 1;
      if (w[6]) seen6 = 1;
    end

    // R10: disable during an active frame; it completes, then nothing starts
    s0 = starts;
    wait (starts == s0 + 1);
    @(posedge clk); poll_en = 1'b0;
    phy_word = 16'h1234;
    wait_valid(found, vcyc);
    check(found && status_word == 16'h1234, "R10 frame in flight completes", status_word, 16'h1234);
    s0 = starts;
    repeat (300) @(posedge clk);
    #1;
    check(starts == s0, "R10 no new frame", starts - s0, 0);

    // R8: reset clears suppression
    rst = 1'b1; repeat (3) @(posedge clk); rst = 1'b0;
    poll_en = 1'b1;
    one_read(16'h0024, 32, 0);
    check(link_up && an_done && !jabber, "R7 link and an", {link_up, an_done}, 2'b11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule